// File: doc/BRIEF.md
# Windowed PCS Configuration Register Bank

This block holds the 16-bit control and status registers of an Ethernet physical coding sublayer. The registers are grouped into four banks: a control/identity bank, a standard MII management bank, a timing-sync bank and a vendor-specific bank. All four are reached through one small bus window. A bank-select register at a fixed offset of the window decides which bank the remaining offsets address. The contents of every bank are also driven out as flat vectors, so neighbouring logic can use the settings directly.

Software talks to the block through a simple synchronous slave port. The port has a byte address into an 8 KiB window, 16-bit write data, write and read strobes, and registered read data. Only aligned 16-bit accesses are honoured. A synchronous hardware reset loads every bank with its fixed defaults and clears the bank select. Software can also request a soft reset by setting the top bit of the MII control register. The soft reset reloads all four banks with their defaults but leaves the bank select alone.

Top module: `pcs_win_regs`

## Requirements
- R1: When `rst` is high at a clock edge, the bank select becomes 0x0000 and every bank register takes its default. Control bank: index 4 = 0x699E, index 8 = 0x8000. MII bank: index 0 = 0x1140, 1 = 0x0109, 2 = 0x699E, 3 = 0xCED0, 4 = 0x0020, 15 = 0xC000. Timing bank: index 8 = 0x0003, 9 = 0x0038, 11 = 0x0038, 13 = 0x0058, 15 = 0x0048. Vendor bank: index 0 = 0x2400, 2 = 0x000A, 6 = 0x899C, 16 = 0x0010, 56 = 0x000A, 58 = 0x007F, 61 = 0x0001, 88 = 0x0100, 89 = 0x1100, 93 = 0x000E, 120 = 0x0100, 121 = 0x0032, 136 = 0x0001, 152 = 0x0019. Every other register defaults to 0x0000.
- R2: A write to byte offset 0x1FE stores all 16 data bits as the bank select. A read of 0x1FE returns the stored value.
- R3: The bank select codes are 0x1E00 (control, 9 registers), 0x1F00 (MII, 16 registers), 0x1F07 (timing, 17 registers) and 0x1F80 (vendor, 227 registers). A read at any other even offset returns the register at index offset/2 of the selected bank. The read data appears on `bus_rdata` after the clock edge that samples `bus_rd`, and it reflects the state before any write in that same cycle.
- R4: A write at an even offset other than 0x1FE updates only the register at index offset/2 of the selected bank, at the clock edge that samples `bus_wr`.
- R5: If the bank select matches none of the four codes, window reads return 0x0000 and window writes change no register.
- R6: An index at or above the selected bank's depth reads as 0x0000, and a write to it changes no register.
- R7: An access at an odd byte offset is misaligned. Its write changes no register and its read returns 0x0000.
- R8: A write to MII index 0 with bit 15 set reloads all four banks with their R1 defaults at that same edge, so MII index 0 then reads 0x1140.
- R9: A soft reset leaves the bank select unchanged. A write to MII index 0 with bit 15 clear simply stores the value. A write with bit 15 set to index 0 of any other bank causes no reload.
- R10: `bus_rdata` holds its value in every cycle without a read strobe, including cycles with writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte offset within the 8 KiB window |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| sel_q | output | 16 | Current bank select value |
| ctl_q | output | 144 | Control bank contents, index i at bits [16i+15:16i] |
| mii_q | output | 256 | MII bank contents, same packing |
| tim_q | output | 272 | Timing bank contents, same packing |
| ven_q | output | 3632 | Vendor bank contents, same packing |

## Verification
The bench writes one past the last index of each bank and at odd offsets. A design with a loose range or alignment check would corrupt a neighbouring register there, or return stale data instead of zero. A near-miss bank code such as 0x1F01 is also tried: a decoder that compares only some bits would then write a real bank. Soft reset is checked for all of these: it clears every bank and not just the MII bank, it keeps the bank select, and it fires neither for bit 15 written to another bank's index 0 nor for a clear bit 15. Random traffic over mixed bank selects, with mid-run hardware resets, is compared against a model on every read and against all the exposed bank contents.

// File: rtl/pcs_win_pkg.sv
package pcs_win_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 13;
    localparam int IDX_W    = ADDR_W - 1;
    localparam int NUM_BANK = 4;

    localparam int CTL_DEPTH = 9;
    localparam int MII_DEPTH = 16;
    localparam int TIM_DEPTH = 17;
    localparam int VEN_DEPTH = 227;

    localparam logic [ADDR_W-1:0] SEL_OFS  = 13'h1FE;
    localparam logic [DATA_W-1:0] CODE_CTL = 16'h1E00;
    localparam logic [DATA_W-1:0] CODE_MII = 16'h1F00;
    localparam logic [DATA_W-1:0] CODE_TIM = 16'h1F07;
    localparam logic [DATA_W-1:0] CODE_VEN = 16'h1F80;

    localparam int SOFT_RST_BIT = 15;

    typedef enum logic [1:0] {
        BK_CTL = 2'd0,
        BK_MII = 2'd1,
        BK_TIM = 2'd2,
        BK_VEN = 2'd3
    } bank_e;

    typedef struct packed {
        logic                sel_reg;
        logic                aligned;
        logic [NUM_BANK-1:0] hit;
        logic [IDX_W-1:0]    idx;
    } win_dec_t;

    function automatic logic [DATA_W-1:0] reg_default(bank_e b, int i);
        logic [DATA_W-1:0] v;
        v = '0;
        case (b)
            BK_CTL: case (i)
                4: v = 16'h699E;
                8: v = 16'h8000;
                default: v = '0;
            endcase
            BK_MII: case (i)
                0:  v = 16'h1140;
                1:  v = 16'h0109;
                2:  v = 16'h699E;
                3:  v = 16'hCED0;
                4:  v = 16'h0020;
                15: v = 16'hC000;
                default: v = '0;
            endcase
            BK_TIM: case (i)
                8:  v = 16'h0003;
                9:  v = 16'h0038;
                11: v = 16'h0038;
                13: v = 16'h0058;
                15: v = 16'h0048;
                default: v = '0;
            endcase
            BK_VEN: case (i)
                0:   v = 16'h2400;
                2:   v = 16'h000A;
                6:   v = 16'h899C;
                16:  v = 16'h0010;
                56:  v = 16'h000A;
                58:  v = 16'h007F;
                61:  v = 16'h0001;
                88:  v = 16'h0100;
                89:  v = 16'h1100;
                93:  v = 16'h000E;
                120: v = 16'h0100;
                121: v = 16'h0032;
                136: v = 16'h0001;
                152: v = 16'h0019;
                default: v = '0;
            endcase
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pcs_win_decode.sv
module pcs_win_decode
    import pcs_win_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] sel,
    output win_dec_t          dec
);
    always_comb begin
        dec.sel_reg     = (addr == SEL_OFS);
        dec.aligned     = ~addr[0];
        dec.idx         = addr[ADDR_W-1:1];
        dec.hit[BK_CTL] = (sel == CODE_CTL);
        dec.hit[BK_MII] = (sel == CODE_MII);
        dec.hit[BK_TIM] = (sel == CODE_TIM);
        dec.hit[BK_VEN] = (sel == CODE_VEN);
    end
endmodule

// File: rtl/pcs_win_bank.sv
module pcs_win_bank
    import pcs_win_pkg::*;
#(
    parameter bank_e BANK  = BK_CTL,
    parameter int    DEPTH = 9,
    localparam int   FLAT_W = DEPTH * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [FLAT_W-1:0] regs_flat,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                q <= reg_default(BANK, g);
            end else if (wr_en && (idx == IDX_W'(g))) begin
                q <= wdata;
            end
        end
        assign regs_flat[g*DATA_W +: DATA_W] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_data = regs_flat[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/pcs_win_regs.sv
module pcs_win_regs
    import pcs_win_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [DATA_W-1:0]             sel_q,
    output logic [CTL_DEPTH*DATA_W-1:0]   ctl_q,
    output logic [MII_DEPTH*DATA_W-1:0]   mii_q,
    output logic [TIM_DEPTH*DATA_W-1:0]   tim_q,
    output logic [VEN_DEPTH*DATA_W-1:0]   ven_q
);
    win_dec_t            dec;
    logic [NUM_BANK-1:0] bank_we;
    logic                win_wr;
    logic                soft_rst;
    logic [DATA_W-1:0]   rd_ctl, rd_mii, rd_tim, rd_ven;
    logic [DATA_W-1:0]   rd_next;

    pcs_win_decode u_dec (
        .addr (bus_addr),
        .sel  (sel_q),
        .dec  (dec)
    );

    assign win_wr   = bus_wr && dec.aligned && !dec.sel_reg;
    assign bank_we  = {NUM_BANK{win_wr}} & dec.hit;
    assign soft_rst = bank_we[BK_MII] && (dec.idx == '0) && bus_wdata[SOFT_RST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (bus_wr && dec.sel_reg) begin
            sel_q <= bus_wdata;
        end
    end

    pcs_win_bank #(.BANK(BK_CTL), .DEPTH(CTL_DEPTH)) u_ctl (
        .clk (clk), .rst (rst), .clear (soft_rst), .wr_en (bank_we[BK_CTL]),
        .idx (dec.idx), .wdata (bus_wdata), .regs_flat (ctl_q), .rd_data (rd_ctl)
    );
    pcs_win_bank #(.BANK(BK_MII), .DEPTH(MII_DEPTH)) u_mii (
        .clk (clk), .rst (rst), .clear (soft_rst), .wr_en (bank_we[BK_MII]),
        .idx (dec.idx), .wdata (bus_wdata), .regs_flat (mii_q), .rd_data (rd_mii)
    );
    pcs_win_bank #(.BANK(BK_TIM), .DEPTH(TIM_DEPTH)) u_tim (
        .clk (clk), .rst (rst), .clear (soft_rst), .wr_en (bank_we[BK_TIM]),
        .idx (dec.idx), .wdata (bus_wdata), .regs_flat (tim_q), .rd_data (rd_tim)
    );
    pcs_win_bank #(.BANK(BK_VEN), .DEPTH(VEN_DEPTH)) u_ven (
        .clk (clk), .rst (rst), .clear (soft_rst), .wr_en (bank_we[BK_VEN]),
        .idx (dec.idx), .wdata (bus_wdata), .regs_flat (ven_q), .rd_data (rd_ven)
    );

    always_comb begin
        if (dec.sel_reg) begin
            rd_next = sel_q;
        end else if (!dec.aligned) begin
            rd_next = '0;
        end else begin
            rd_next = ({DATA_W{dec.hit[BK_CTL]}} & rd_ctl)
                    | ({DATA_W{dec.hit[BK_MII]}} & rd_mii)
                    | ({DATA_W{dec.hit[BK_TIM]}} & rd_tim)
                    | ({DATA_W{dec.hit[BK_VEN]}} & rd_ven);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/pcs_win_regs_chk.sv
module pcs_win_regs_chk
    import pcs_win_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [DATA_W-1:0]           sel_q,
    input logic [CTL_DEPTH*DATA_W-1:0] ctl_q,
    input logic [MII_DEPTH*DATA_W-1:0] mii_q,
    input logic [TIM_DEPTH*DATA_W-1:0] tim_q,
    input logic [VEN_DEPTH*DATA_W-1:0] ven_q
);
    logic bad_code;
    assign bad_code = (sel_q != CODE_CTL) && (sel_q != CODE_MII)
                   && (sel_q != CODE_TIM) && (sel_q != CODE_VEN);

    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == SEL_OFS) |=> (sel_q == $past(bus_wdata))); // R2

    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == SEL_OFS) |=> $stable(sel_q)); // R9

    AST_BAD_BANK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bad_code && bus_addr != SEL_OFS)
        |=> ($stable(ctl_q) && $stable(mii_q) && $stable(tim_q) && $stable(ven_q))); // R5

    AST_ODD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[0])
        |=> ($stable(ctl_q) && $stable(mii_q) && $stable(tim_q) && $stable(ven_q))); // R7

    AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_q == CODE_MII && bus_addr == '0 && bus_wdata[SOFT_RST_BIT])
        |=> (mii_q[DATA_W-1:0] == 16'h1140 && ctl_q[4*DATA_W +: DATA_W] == 16'h699E
             && ven_q[DATA_W-1:0] == 16'h2400)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

bind pcs_win_regs pcs_win_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .sel_q     (sel_q),
    .ctl_q     (ctl_q),
    .mii_q     (mii_q),
    .tim_q     (tim_q),
    .ven_q     (ven_q)
);

// File: tb/pcs_win_regs_test.sv
module pcs_win_regs_test;
    localparam int DW = 16;
    localparam int DEP [4] = '{9, 16, 17, 227};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [12:0]     bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [DW-1:0]   bus_rdata, sel_q;
    logic [9*DW-1:0]   ctl_q;
    logic [16*DW-1:0]  mii_q;
    logic [17*DW-1:0]  tim_q;
    logic [227*DW-1:0] ven_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] m [0:3][0:226];
    logic [DW-1:0] m_sel;

    always #10 clk = ~clk;

    pcs_win_regs uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sel_q(sel_q),
        .ctl_q(ctl_q), .mii_q(mii_q), .tim_q(tim_q), .ven_q(ven_q)
    );

    // defaults by bank and byte offset (R1)
    function automatic logic [DW-1:0] bdef(int b, int ofs);
        if (b == 0) begin
            if (ofs == 'h08) return 16'h699E;
            if (ofs == 'h10) return 16'h8000;
        end else if (b == 1) begin
            case (ofs)
                'h00: return 16'h1140;  'h02: return 16'h0109;
                'h04: return 16'h699E;  'h06: return 16'hCED0;
                'h08: return 16'h0020;  'h1E: return 16'hC000;
                default: return 16'h0000;
            endcase
        end else if (b == 2) begin
            case (ofs)
                'h10: return 16'h0003;  'h12: return 16'h0038;
                'h16: return 16'h0038;  'h1A: return 16'h0058;
                'h1E: return 16'h0048;
                default: return 16'h0000;
            endcase
        end else begin
            case (ofs)
                'h000: return 16'h2400; 'h004: return 16'h000A;
                'h00C: return 16'h899C; 'h020: return 16'h0010;
                'h070: return 16'h000A; 'h074: return 16'h007F;
                'h07A: return 16'h0001; 'h0B0: return 16'h0100;
                'h0B2: return 16'h1100; 'h0BA: return 16'h000E;
                'h0F0: return 16'h0100; 'h0F2: return 16'h0032;
                'h110: return 16'h0001; 'h130: return 16'h0019;
                default: return 16'h0000;
            endcase
        end
        return 16'h0000;
    endfunction

    function automatic int code2bank(logic [DW-1:0] c);
        case (c)
            16'h1E00: return 0;
            16'h1F00: return 1;
            16'h1F07: return 2;
            16'h1F80: return 3;
            default:  return -1;
        endcase
    endfunction

    task automatic load_defaults();
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 227; i++)
                m[b][i] = (i < DEP[b]) ? bdef(b, 2*i) : 16'h0000;
    endtask

    function automatic logic [DW-1:0] model_read(logic [12:0] a);
        int b, idx;
        if (a == 13'h1FE) return m_sel;
        if (a[0]) return 16'h0000;
        b = code2bank(m_sel);
        if (b < 0) return 16'h0000;
        idx = int'(a >> 1);
        if (idx >= DEP[b]) return 16'h0000;
        return m[b][idx];
    endfunction

    task automatic model_write(logic [12:0] a, logic [DW-1:0] d);
        int b, idx;
        if (a == 13'h1FE) begin m_sel = d; return; end
        if (a[0]) return;
        b = code2bank(m_sel);
        if (b < 0) return;
        idx = int'(a >> 1);
        if (idx >= DEP[b]) return;
        m[b][idx] = d;
        if (b == 1 && idx == 0 && d[15]) load_defaults();
    endtask

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int bad = 0;
        logic [DW-1:0] a, e;
        checks++;
        a = sel_q; e = m_sel;
        if (sel_q !== m_sel) bad++;
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < DEP[b]; i++) begin
                logic [DW-1:0] v;
                case (b)
                    0: v = ctl_q[i*DW +: DW];
                    1: v = mii_q[i*DW +: DW];
                    2: v = tim_q[i*DW +: DW];
                    default: v = ven_q[i*DW +: DW];
                endcase
                if (v !== m[b][i]) begin
                    if (bad == 0) begin a = v; e = m[b][i]; end
                    bad++;
                end
            end
        end
        if (bad != 0) begin
            errors++;
            $display("FAIL %s bank contents (%0d mismatches) actual=%h expected=%h",
                     tag, bad, a, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        load_defaults();
        m_sel = 16'h0000;
    endtask

    task automatic wr(logic [12:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(logic [12:0] a, string tag);
        logic [DW-1:0] e;
        e = model_read(a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'd20240611));
        do_reset();
        check_all("R1 reset defaults");
        rd(13'h1FE, "R1 select cleared");

        wr(13'h1FE, 16'h1F00);
        rd(13'h1FE, "R2 select readback");
        rd(13'h000, "R3 mii idx0");
        rd(13'h01E, "R3 mii idx15");
        wr(13'h1FE, 16'h1E00);
        rd(13'h008, "R3 ctl idx4");
        rd(13'h010, "R3 ctl idx8");

        wr(13'h1FE, 16'h1F07);
        rd(13'h01A, "R3 tim idx13");
        wr(13'h020, 16'hBEEF);
        rd(13'h020, "R4 tim last index");
        check_all("R4 only target changed");

        wr(13'h1FE, 16'h1F80);
        rd(13'h130, "R3 ven idx152");
        wr(13'h1C4, 16'h1234);
        rd(13'h1C4, "R4 ven last index");
        wr(13'h1C6, 16'h5555);
        check_all("R6 ven beyond depth write");
        rd(13'h1C6, "R6 ven beyond depth read");

        wr(13'h1FE, 16'h1E00);
        wr(13'h012, 16'h6666);
        check_all("R6 ctl beyond depth write");
        rd(13'h012, "R6 ctl beyond depth read");

        wr(13'h1FE, 16'h1F01);
        wr(13'h000, 16'hAAAA);
        check_all("R5 bad code write");
        rd(13'h000, "R5 bad code read");
        wr(13'h1FE, 16'h0000);
        wr(13'h004, 16'hAAAA);
        check_all("R5 zero code write");
        rd(13'h1FE, "R2 select keeps bad code");

        wr(13'h1FE, 16'h1F07);
        wr(13'h011, 16'h7777);
        check_all("R7 odd write");
        rd(13'h011, "R7 odd read");
        rd(13'h1FF, "R7 odd next to select");

        wr(13'h1FE, 16'h1F00);
        wr(13'h000, 16'h0140);
        rd(13'h000, "R9 no-reset control write");
        check_all("R9 clear bit keeps other banks");
        wr(13'h000, 16'h8000);
        check_all("R8 soft reset reloads all");
        rd(13'h000, "R8 control reads default");
        rd(13'h1FE, "R9 select kept over soft reset");

        wr(13'h1FE, 16'h1F80);
        wr(13'h002, 16'h4444);
        wr(13'h1FE, 16'h1E00);
        wr(13'h000, 16'h8000);
        check_all("R9 bit15 to ctl idx0 no reload");

        // R10: rdata holds across idle and write cycles
        rd(13'h000, "R3 ctl idx0 after write");
        held = bus_rdata;
        wr(13'h002, 16'h9999);
        repeat (3) @(negedge clk);
        chk("R10 rdata held", bus_rdata, held);

        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [12:0] a;
            logic [DW-1:0] d;
            op = int'($urandom % 100);
            d = 16'($urandom);
            if (op < 15) begin
                case ($urandom % 6)
                    0: d = 16'h1E00;
                    1: d = 16'h1F00;
                    2: d = 16'h1F07;
                    3: d = 16'h1F80;
                    4: d = 16'h1F80;
                    default: d = d;
                endcase
                wr(13'h1FE, d);
            end else begin
                int b;
                int lim;
                b = code2bank(m_sel);
                lim = (b < 0) ? 20 : DEP[b] + 3;
                a = 13'(2 * ($urandom % lim));
                if ($urandom % 16 == 0) a = a | 13'h1;
                if (op < 55) wr(a, d);
                else rd(a, "R3 random read");
            end
            if (n % 250 == 249) check_all("R4 random contents");
            if (n == 900) begin
                wr(13'h1FE, 16'h1F07);
                do_reset();
                check_all("R1 mid-run reset");
                rd(13'h1FE, "R1 select zero after reset");
            end
        end
        check_all("R4 final contents");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule